// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between the local bus of a PCIe root complex and its transaction layer. Local read and write addresses that fall inside a fixed 256 MB outbound window are looked up in a table of translation regions. The block returns a PCIe bus address built from the selected region's base and the untouched offset inside that region. Addresses outside the window, in a disabled region, or beyond the populated table raise a miss instead of a translation.

One region size is shared by the whole window and chosen by software: 1, 2, 4 or 8 MB. At 8 MB the 32 table entries cover the entire window. At smaller sizes only the lower part of the window is reachable, and indices past the table miss. Each table entry holds a translated base in its upper bits and an enable in bit 0. A small register port programs the size and the table.

Requests arrive on a valid/ready stream, and results leave on a valid/ready stream with one register stage between them. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its result is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result and all its flags hold still.

Top module: `ob_xlate`

## Requirements
- R1: The window is local addresses 0x6000_0000 to 0x6FFF_FFFF inclusive. Any request outside it returns a miss.
- R2: Config address 0 holds the region size in bits [1:0], encoded 0=1 MB, 1=2 MB, 2=4 MB, 3=8 MB. It resets to 0, and its other bits read as zero.
- R3: Config address 32+i holds table entry i for i in 0..31. Bits [31:20] are the translated base, bit 0 is the enable, and all other bits read as zero. Every entry resets to zero, which means disabled.
- R4: The entry index is the window offset (the address minus 0x6000_0000) shifted right by 20+size. Entry 0 covers the bottom of the window.
- R5: On a hit, the output address is the entry base with the bits below the region size cleared, ORed with the address bits below the region size. The in-region offset is therefore kept unchanged.
- R6: A request whose entry is disabled, or whose index is 32 or more, returns a miss.
- R7: A request taken at one edge gives `rsp_valid` after that edge. While `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high. When `rsp_valid` is low, both are low. On a miss, `rsp_addr` is zero.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the result holds stable. `req_ready` equals `!rsp_valid || rsp_ready`.
- R9: A config write applies to requests taken at later edges. A request taken on the same edge as the write, or already held in the output stage, keeps its result.
- R10: Config addresses 1 to 31 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Translated PCIe address, zero on miss |
| rsp_hit | output | 1 | Result is a valid translation |
| rsp_miss | output | 1 | Result is a miss |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 6 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr`, combinational |

## Verification
Two cases are hard to reach from the ports. The first is a config write on the very edge that takes a request. The second is a write that lands while a result is held by back-pressure. The bench drives the write strobe and the request together in one cycle, then checks the result against the table as it stood before the write. It then stalls the consumer, rewrites the entry behind the held result, and checks that the held result does not change. Random traffic reprograms the size and entries between bursts, so that edge indices such as the last populated entry and the first unpopulated one are hit under every size.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int XAW = 32;

  typedef enum logic [1:0] {
    RSZ_1M = 2'd0,
    RSZ_2M = 2'd1,
    RSZ_4M = 2'd2,
    RSZ_8M = 2'd3
  } rsize_e;

  typedef struct packed {
    logic           hit;
    logic           miss;
    logic [XAW-1:0] addr;
  } xl_res_t;
endpackage

// File: rtl/ob_xlate_cfg.sv
module ob_xlate_cfg
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 32,
  parameter int MIN_SHIFT   = 20,
  parameter int CFG_AW      = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_wr,
  input  logic [CFG_AW-1:0]                      cfg_addr,
  input  logic [XAW-1:0]                         cfg_wdata,
  output logic [XAW-1:0]                         cfg_rdata,
  output rsize_e                                 size_q,
  output logic [NUM_REGIONS-1:0][XAW-MIN_SHIFT-1:0] base_q,
  output logic [NUM_REGIONS-1:0]                 en_q
);
  localparam int RIW = $clog2(NUM_REGIONS);
  localparam int BW  = XAW - MIN_SHIFT;

  logic tbl_sel;
  logic [RIW-1:0] tbl_idx;
  logic unused_wbits;

  assign tbl_sel = cfg_addr[CFG_AW-1];
  assign tbl_idx = cfg_addr[RIW-1:0];
  assign unused_wbits = ^cfg_wdata[MIN_SHIFT-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= RSZ_1M;
    else if (cfg_wr && cfg_addr == '0) size_q <= rsize_e'(cfg_wdata[1:0]);
  end

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[gi] <= '0;
        en_q[gi]   <= 1'b0;
      end else if (cfg_wr && tbl_sel && tbl_idx == RIW'(gi)) begin
        base_q[gi] <= cfg_wdata[XAW-1:MIN_SHIFT];
        en_q[gi]   <= cfg_wdata[0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (tbl_sel) cfg_rdata = {base_q[tbl_idx], {(MIN_SHIFT-1){1'b0}}, en_q[tbl_idx]};
    else if (cfg_addr == '0) cfg_rdata = {{(XAW-2){1'b0}}, size_q};
  end

  a_r2_size_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == '0) |=> (size_q == $past(cfg_wdata[1:0])));

  a_r3_entry0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && tbl_sel && tbl_idx == '0) |=>
      (en_q[0] == $past(cfg_wdata[0]) && base_q[0] == $past(cfg_wdata[XAW-1:MIN_SHIFT])));

  a_r10_gap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !tbl_sel && cfg_addr != '0) |=> ($stable(size_q) && $stable(en_q) && $stable(base_q)));

  localparam int BW_CHK = BW;
  initial assert (BW_CHK > 0 && NUM_REGIONS <= (1 << (CFG_AW-1)));
endmodule

// File: rtl/ob_xlate_map.sv
module ob_xlate_map
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 32,
  parameter int MIN_SHIFT   = 20,
  parameter int WIN_BITS    = 28,
  parameter logic [XAW-1:0] WIN_BASE = 32'h6000_0000
) (
  input  logic [XAW-1:0]                            addr,
  input  rsize_e                                    size,
  input  logic [NUM_REGIONS-1:0][XAW-MIN_SHIFT-1:0] base_q,
  input  logic [NUM_REGIONS-1:0]                    en_q,
  output xl_res_t                                   res
);
  localparam int RIW = $clog2(NUM_REGIONS);
  localparam logic [XAW-1:0] WIN_MASK = (XAW'(1) << WIN_BITS) - XAW'(1);

  logic                in_win;
  logic [WIN_BITS-1:0] off;
  logic [WIN_BITS-1:0] idx_full;
  logic [RIW-1:0]      sel;
  logic                populated;
  logic [XAW-1:0]      lomask;
  logic [XAW-1:0]      base_full;
  int                  sh;

  always_comb begin
    in_win    = (addr & ~WIN_MASK) == WIN_BASE;
    off       = addr[WIN_BITS-1:0];
    sh        = MIN_SHIFT + int'(size);
    idx_full  = off >> sh;
    populated = idx_full < WIN_BITS'(NUM_REGIONS);
    sel       = idx_full[RIW-1:0];
    lomask    = (XAW'(1) << sh) - XAW'(1);
    base_full = {base_q[sel], {MIN_SHIFT{1'b0}}};
    res.hit   = in_win && populated && en_q[sel];
    res.miss  = !res.hit;
    res.addr  = res.hit ? ((base_full & ~lomask) | ({{(XAW-WIN_BITS){1'b0}}, off} & lomask)) : '0;
  end
endmodule

// File: rtl/ob_xlate_stage.sv
module ob_xlate_stage
  import ob_xlate_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  xl_res_t        in_res,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [XAW-1:0] out_addr,
  output logic           out_hit,
  output logic           out_miss
);
  logic    v_q;
  xl_res_t r_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      r_q <= '0;
    end else if (in_valid && in_ready) begin
      v_q <= 1'b1;
      r_q <= in_res;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  assign out_valid = v_q;
  assign out_addr  = v_q ? r_q.addr : '0;
  assign out_hit   = v_q && r_q.hit;
  assign out_miss  = v_q && r_q.miss;

  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_hit, out_miss}));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && !out_miss));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_addr == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_hit)));
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 32,
  parameter int MIN_SHIFT   = 20,
  parameter int WIN_BITS    = 28,
  parameter logic [31:0] WIN_BASE = 32'h6000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_hit,
  output logic        rsp_miss,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);
  localparam int CFG_AW = $clog2(NUM_REGIONS) + 1;
  localparam logic [31:0] WIN_MASK = (32'd1 << WIN_BITS) - 32'd1;

  rsize_e                                     size_q;
  logic [NUM_REGIONS-1:0][XAW-MIN_SHIFT-1:0]  base_q;
  logic [NUM_REGIONS-1:0]                     en_q;
  xl_res_t                                    lk_res;

  ob_xlate_cfg #(.NUM_REGIONS(NUM_REGIONS), .MIN_SHIFT(MIN_SHIFT), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr[CFG_AW-1:0]),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .size_q(size_q),
    .base_q(base_q), .en_q(en_q)
  );

  ob_xlate_map #(.NUM_REGIONS(NUM_REGIONS), .MIN_SHIFT(MIN_SHIFT),
                 .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) u_map (
    .addr(req_addr), .size(size_q), .base_q(base_q), .en_q(en_q), .res(lk_res)
  );

  ob_xlate_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready), .in_res(lk_res),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_addr(rsp_addr),
    .out_hit(rsp_hit), .out_miss(rsp_miss)
  );

  a_r1_outside_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ((req_addr & ~WIN_MASK) != WIN_BASE)) |=> rsp_miss);

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!rsp_hit || rsp_addr[MIN_SHIFT-1:0] == $past(req_addr[MIN_SHIFT-1:0])));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));
endmodule

// File: tb/sim_ob_xlate.sv
module sim_ob_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, cfg_wr = 1'b0;
  logic [31:0] req_addr = '0, cfg_wdata = '0;
  logic [5:0]  cfg_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_addr, cfg_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0]  m_sz = 2'd0;
  logic [11:0] m_base [32];
  logic        m_en   [32];

  always #4 clk = ~clk;

  ob_xlate u0 (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [33:0] model(logic [31:0] a);
    logic [27:0] off;
    logic [31:0] lm, b;
    int sh, idx;
    if (a[31:28] != 4'h6) return {2'b01, 32'h0};
    off = a[27:0];
    sh  = 20 + int'(m_sz);
    idx = int'(off >> sh);
    if (idx >= 32) return {2'b01, 32'h0};
    if (!m_en[idx]) return {2'b01, 32'h0};
    lm = (32'd1 << sh) - 1;
    b  = {m_base[idx], 20'h0};
    return {2'b10, (b & ~lm) | ({4'h0, off} & lm)};
  endfunction

  task automatic mupd(logic [5:0] a, logic [31:0] d);
    if (a == 0) m_sz = d[1:0];
    else if (a[5]) begin
      m_base[a[4:0]] = d[31:20];
      m_en[a[4:0]]   = d[0];
    end
  endtask

  task automatic cwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    mupd(a, d);
  endtask

  task automatic crd(string rq, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(rq, cfg_rdata, exp);
  endtask

  task automatic xl(string rq, logic [31:0] a);
    logic [33:0] e;
    e = model(a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({rq, " valid"}, 32'(rsp_valid), 32'd1);
    chk({rq, " flags"}, {30'h0, rsp_hit, rsp_miss}, {30'h0, e[33:32]});
    chk({rq, " addr"}, rsp_addr, e[31:0]);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [33:0] e0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin m_base[i] = '0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R7 reset valid", 32'(rsp_valid), 0);
    chk("R8 reset ready", 32'(req_ready), 1);
    crd("R2 reset size", 6'd0, 0);
    crd("R3 reset entry0", 6'd32, 0);
    crd("R3 reset entry31", 6'd63, 0);
    xl("R3 reset disabled", 32'h6000_0000);

    // R3 readback masks middle bits
    cwr(6'd33, 32'h0020_0FFF);
    crd("R3 readback", 6'd33, 32'h0020_0001);
    // R10 gap register
    cwr(6'd5, 32'hFFFF_FFFF);
    crd("R10 gap read", 6'd5, 0);
    crd("R10 size untouched", 6'd0, 0);

    // R4/R5 1 MB, offsets preserved
    cwr(6'd32, 32'h0020_0001);
    xl("R5 off0", 32'h6000_0000);
    xl("R5 off4", 32'h6000_0004);
    xl("R5 off8", 32'h6000_0008);
    xl("R4 entry1", 32'h6010_0ABC);
    xl("R6 disabled entry2", 32'h6020_0000);
    xl("R6 index32 unpopulated", 32'h6200_0000);
    xl("R1 above window", 32'h7000_0000);
    xl("R1 below window", 32'h5FFF_FFFC);

    // R2/R5 8 MB: base low bits ignored
    cwr(6'd0, 32'h0000_0003);
    crd("R2 size read", 6'd0, 3);
    cwr(6'd32, 32'h0030_0001);
    xl("R5 base low ignored", 32'h6000_0010);
    cwr(6'd63, 32'hABC0_0001);
    xl("R1 top of window", 32'h6FFF_FFFF);
    cwr(6'd0, 32'h0000_0001);
    xl("R4 2MB index", 32'h6030_0004);

    // R9 write on same edge as request
    e0 = model(32'h6000_0040);
    @(negedge clk);
    req_valid = 1; req_addr = 32'h6000_0040;
    cfg_wr = 1; cfg_addr = 6'd32; cfg_wdata = 32'h0;
    @(negedge clk);
    req_valid = 0; cfg_wr = 0;
    mupd(6'd32, 32'h0);
    chk("R9 same edge old table", {rsp_hit, rsp_miss, rsp_addr[29:0]}, {e0[33:32], e0[29:0]});
    xl("R9 after write", 32'h6000_0040);

    // R8 back-pressure and R9 write under stall
    cwr(6'd32, 32'h0500_0001);
    e0 = model(32'h6000_1234);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'h6000_1234;
    @(negedge clk);
    req_addr = 32'h6000_0008;
    chk("R8 ready low", 32'(req_ready), 0);
    cfg_wr = 1; cfg_addr = 6'd32; cfg_wdata = 32'h0900_0001;
    @(negedge clk);
    cfg_wr = 0;
    mupd(6'd32, 32'h0900_0001);
    @(negedge clk);
    chk("R8 held valid", 32'(rsp_valid), 1);
    chk("R9 held addr", rsp_addr, e0[31:0]);
    chk("R8 held flag", 32'(rsp_hit), 32'(e0[33]));
    e0 = model(32'h6000_0008);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 second accepted", rsp_addr, e0[31:0]);
    @(negedge clk);
    chk("R7 drained", {31'h0, rsp_valid}, 0);
    chk("R7 drained flags", {30'h0, rsp_hit, rsp_miss}, 0);

    // random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if (n % 40 == 0) begin
        cwr(6'd0, $urandom);
        for (int k = 0; k < 8; k++) cwr(6'(32 + ($urandom % 32)), $urandom);
      end
      a = ($urandom % 8 == 0) ? $urandom : (32'h6000_0000 | ($urandom & 32'h0FFF_FFFF));
      if ($urandom % 3 == 0) a = 32'h6000_0000 | (32'(m_sz + 0) << 28 >> 28) | ($urandom & 32'h03FF_FFFF);
      xl("R4 R5 R6 random", a);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule